// File: doc/BRIEF.md
# Second-Stage Address Walker

This block turns a guest physical address into a host physical address by walking multi-level second-stage page tables held in memory. A client presents one address together with a translation configuration. The configuration has four parts: a mode code, the page number of the root table, a select between a 32-bit and a 64-bit table format, and a set of capability bits that enable each mode. The walker reads one table entry at a time over a simple request/response memory port, checks each entry, and returns either the translated address or a fault. In bare mode the address comes back unchanged and memory is never touched.

The walker is a five-state machine and handles one translation at a time:

- **IDLE**: waits for a request. It moves to CHECK on `req_valid`, latching the address and the configuration.
- **CHECK**: decodes the mode and tests the address range.
  - It goes to DONE for bare mode, an illegal or disabled mode, or an out-of-range address.
  - Otherwise it loads the root base and goes to READ.
- **READ**: issues one entry read and moves to WAIT.
- **WAIT**: holds until a response arrives.
  - It returns to READ when the entry points to the next table and levels remain.
  - It goes to DONE on a leaf, on any fault, or when a pointer appears at the last level.
- **DONE**: presents the result for one cycle and then returns to IDLE.

Top module: `gstage_walker`

## Requirements
- R1: While reset is held and just after it, `req_ready` is 1 and both `mem_req_valid` and `done_valid` are 0.
- R2: With mode code 0 (bare), the walker returns `done_pa` equal to `req_gpa` with `done_fault` 0, and it issues no memory read.
- R3: Mode legality depends on `cfg_narrow`.
  - When `cfg_narrow` is 1, only mode 1 is legal: 2 levels, 10 index bits, 4-byte entries, enabled by `cfg_cap[0]`.
  - When `cfg_narrow` is 0, modes 8, 9 and 10 are legal: 3, 4 and 5 levels, 9 index bits, 8-byte entries, enabled by `cfg_cap[1]`, `cfg_cap[2]` and `cfg_cap[3]` respectively.
  - Any other mode code, or a legal mode whose capability bit is clear, faults with no memory read.
- R4: An address with any bit set at or above position 14 + index_bits × levels (34, 41, 50 or 59) faults with no memory read. The highest bit below that limit is accepted.
- R5: Entry addressing works as follows.
  - Each entry address is the table base plus the index times the entry size.
  - The index is taken from the address starting at bit 12 + index_bits × (levels − 1 − step).
  - The index is index_bits wide, and 2 bits wider at step 0.
  - `mem_req_wide` is 1 for 8-byte reads and 0 for 4-byte reads.
  - A 4-byte entry is the low 32 bits of `mem_rsp_data`.
- R6: An entry whose bit 0 (valid) is clear faults.
- R7: A valid entry with bits 1, 2 and 3 (read, write, execute) all clear is a pointer. Its page number, taken from bit 10 upward, shifted left by 12 becomes the next table base.
- R8: A leaf with write set and read clear faults. This covers write only, and write plus execute.
- R9: A leaf faults when its page number has any nonzero bit below 9 × (levels − 1 − step) for 64-bit tables, or 10 × (levels − 1 − step) for 32-bit tables.
- R10: A good leaf at step s returns the page number shifted left by 12, ORed with the address bits below 12 + index_bits × (levels − 1 − s).
- R11: A pointer found at the last level faults.
- R12: A response with `mem_rsp_err` set ends the walk with a fault on the next cycle and issues no further reads.
- R13: `mem_req_valid` is a one-cycle pulse with an address aligned to the entry size. No new read is issued before the response to the previous one.
- R14: A request is taken when `req_valid` and `req_ready` are both high. `done_valid` is high for exactly one cycle, after which `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_gpa | input | ADDR_W | Guest physical address |
| cfg_mode | input | 4 | Mode code |
| cfg_narrow | input | 1 | 1 selects the 32-bit table format |
| cfg_cap | input | CAP_W | Mode enable bits |
| cfg_root_ppn | input | ROOT_W | Root table page number |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | ADDR_W | Entry byte address |
| mem_req_wide | output | 1 | 1 = 8-byte read, 0 = 4-byte read |
| mem_rsp_valid | input | 1 | Read response |
| mem_rsp_data | input | DATA_W | Entry data, little-endian |
| mem_rsp_err | input | 1 | Read error |
| done_valid | output | 1 | Result strobe |
| done_fault | output | 1 | Walk faulted |
| done_pa | output | ADDR_W | Translated address |

## Verification
The bench sweeps every mode code against every capability mask in both table formats. A walker with a faulty mode decode would read memory for a disabled mode or fault on an enabled one. For every level depth it plants a leaf at each step, with all 16 flag patterns and with both aligned and misaligned page numbers. A wrong index width or shift would read the wrong entry, and a wrong span mask would accept a misaligned superpage or merge the wrong low bits. The bench also covers the range-limit bit, a pointer at the last level and an erroring first read. A walker that got any of these wrong would keep reading or would return an address where a fault belongs.

// File: rtl/gsw_pkg.sv
package gsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    localparam int MODE_W     = 4;
    localparam int LVL_W      = 3;
    localparam int PAGE_SHIFT = 12;
    localparam int PPN_LSB    = 10;

    localparam logic [MODE_W-1:0] MODE_BARE = 4'd0;
    localparam logic [MODE_W-1:0] MODE_N2   = 4'd1;
    localparam logic [MODE_W-1:0] MODE_W3   = 4'd8;

    typedef struct packed {
        logic             bare;
        logic             legal;
        logic [LVL_W-1:0] levels;
        logic [3:0]       idx_bits;
        logic             wide_pte;
    } geom_t;

endpackage

// File: rtl/gsw_mode_decode.sv
module gsw_mode_decode
    import gsw_pkg::*;
#(
    parameter int CAP_W    = 4,
    parameter int WIDE_CNT = 3
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              narrow,
    input  logic [CAP_W-1:0]  cap,
    output geom_t             geom
);
    logic [WIDE_CNT-1:0] wide_hit;

    for (genvar k = 0; k < WIDE_CNT; k++) begin : g_wide
        assign wide_hit[k] = (mode == MODE_W3 + MODE_W'(k)) && cap[k+1];
    end

    always_comb begin
        geom = '0;
        if (mode == MODE_BARE) begin
            geom.bare  = 1'b1;
            geom.legal = 1'b1;
        end else if (narrow) begin
            if (mode == MODE_N2 && cap[0]) begin
                geom.legal    = 1'b1;
                geom.levels   = 3'd2;
                geom.idx_bits = 4'd10;
                geom.wide_pte = 1'b0;
            end
        end else begin
            for (int k = 0; k < WIDE_CNT; k++) begin
                if (wide_hit[k]) begin
                    geom.legal    = 1'b1;
                    geom.levels   = LVL_W'(3 + k);
                    geom.idx_bits = 4'd9;
                    geom.wide_pte = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gsw_index_gen.sv
module gsw_index_gen
    import gsw_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] gpa,
    input  logic [ADDR_W-1:0] base,
    input  logic [LVL_W-1:0]  levels,
    input  logic [3:0]        idx_bits,
    input  logic              wide_pte,
    input  logic [LVL_W-1:0]  step,
    output logic [ADDR_W-1:0] pte_addr,
    output logic [6:0]        skip,
    output logic              range_ok
);
    logic [LVL_W-1:0]  remaining;
    logic [6:0]        ibits;
    logic [6:0]        top;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        remaining = levels - LVL_W'(1) - step;
        skip      = 7'(PAGE_SHIFT) + 7'(idx_bits) * 7'(remaining);
        ibits     = 7'(idx_bits) + ((step == '0) ? 7'd2 : 7'd0);
        idx       = (gpa >> skip) & ((ADDR_W'(1) << ibits) - ADDR_W'(1));
        pte_addr  = base + (wide_pte ? (idx << 3) : (idx << 2));
        top       = skip + ibits;
        range_ok  = (int'(top) >= ADDR_W) ? 1'b1 : ((gpa >> top) == '0);
    end
endmodule

// File: rtl/gsw_pte_eval.sv
module gsw_pte_eval
    import gsw_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              wide_pte,
    input  logic [6:0]        skip,
    input  logic [ADDR_W-1:0] gpa,
    output logic              is_invalid,
    output logic              is_pointer,
    output logic              is_reserved,
    output logic              is_misaligned,
    output logic [ADDR_W-1:0] next_base,
    output logic [ADDR_W-1:0] leaf_pa
);
    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;

    logic [DATA_W-1:0] pte;
    logic [ADDR_W-1:0] ppn;
    logic [6:0]        span;

    always_comb begin
        pte           = wide_pte ? rsp_data : DATA_W'(rsp_data[31:0]);
        ppn           = ADDR_W'(pte >> PPN_LSB);
        span          = skip - 7'(PAGE_SHIFT);
        is_invalid    = !pte[BIT_V];
        is_pointer    = pte[BIT_V] && !pte[BIT_R] && !pte[BIT_W] && !pte[BIT_X];
        is_reserved   = pte[BIT_W] && !pte[BIT_R];
        is_misaligned = |(ppn & ((ADDR_W'(1) << span) - ADDR_W'(1)));
        next_base     = ppn << PAGE_SHIFT;
        leaf_pa       = next_base | (gpa & ((ADDR_W'(1) << skip) - ADDR_W'(1)));
    end
endmodule

// File: rtl/gstage_walker.sv
module gstage_walker
    import gsw_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int ROOT_W = 44,
    parameter int CAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_gpa,
    input  logic [3:0]        cfg_mode,
    input  logic              cfg_narrow,
    input  logic [CAP_W-1:0]  cfg_cap,
    input  logic [ROOT_W-1:0] cfg_root_ppn,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_wide,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              done_valid,
    output logic              done_fault,
    output logic [ADDR_W-1:0] done_pa
);
    walk_state_e state_q, state_d;

    logic [ADDR_W-1:0] gpa_q, base_q, pa_q;
    logic [MODE_W-1:0] mode_q;
    logic              narrow_q, fault_q;
    logic [CAP_W-1:0]  cap_q;
    logic [ROOT_W-1:0] root_q;
    logic [LVL_W-1:0]  step_q;

    geom_t             geom;
    logic [ADDR_W-1:0] pte_addr;
    logic [6:0]        skip;
    logic              range_ok;
    logic              pte_invalid, pte_pointer, pte_reserved, pte_misaligned;
    logic [ADDR_W-1:0] pte_next_base, pte_leaf_pa;
    logic              last_level, walk_fault, walk_leaf;

    gsw_mode_decode #(.CAP_W(CAP_W)) u_decode (
        .mode   (mode_q),
        .narrow (narrow_q),
        .cap    (cap_q),
        .geom   (geom)
    );

    gsw_index_gen #(.ADDR_W(ADDR_W)) u_index (
        .gpa      (gpa_q),
        .base     (base_q),
        .levels   (geom.levels),
        .idx_bits (geom.idx_bits),
        .wide_pte (geom.wide_pte),
        .step     (step_q),
        .pte_addr (pte_addr),
        .skip     (skip),
        .range_ok (range_ok)
    );

    gsw_pte_eval #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eval (
        .rsp_data      (mem_rsp_data),
        .wide_pte      (geom.wide_pte),
        .skip          (skip),
        .gpa           (gpa_q),
        .is_invalid    (pte_invalid),
        .is_pointer    (pte_pointer),
        .is_reserved   (pte_reserved),
        .is_misaligned (pte_misaligned),
        .next_base     (pte_next_base),
        .leaf_pa       (pte_leaf_pa)
    );

    always_comb begin
        last_level = (LVL_W'(step_q + LVL_W'(1)) == geom.levels);
        walk_leaf  = !pte_invalid && !pte_pointer;
        walk_fault = mem_rsp_err || pte_invalid
                   || (walk_leaf && (pte_reserved || pte_misaligned))
                   || (pte_pointer && last_level);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (geom.bare || !geom.legal || !range_ok) state_d = ST_DONE;
                else                                       state_d = ST_READ;
            end
            ST_READ:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (walk_fault || walk_leaf) state_d = ST_DONE;
                    else                         state_d = ST_READ;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpa_q    <= '0;
            base_q   <= '0;
            pa_q     <= '0;
            mode_q   <= '0;
            narrow_q <= 1'b0;
            cap_q    <= '0;
            root_q   <= '0;
            step_q   <= '0;
            fault_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        gpa_q    <= req_gpa;
                        mode_q   <= cfg_mode;
                        narrow_q <= cfg_narrow;
                        cap_q    <= cfg_cap;
                        root_q   <= cfg_root_ppn;
                        fault_q  <= 1'b0;
                        pa_q     <= '0;
                        step_q   <= '0;
                    end
                end
                ST_CHECK: begin
                    step_q <= '0;
                    base_q <= ADDR_W'(root_q) << PAGE_SHIFT;
                    if (geom.bare)                        pa_q    <= gpa_q;
                    else if (!geom.legal || !range_ok)    fault_q <= 1'b1;
                end
                ST_READ: ;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (walk_fault)     fault_q <= 1'b1;
                        else if (walk_leaf) pa_q    <= pte_leaf_pa;
                        else begin
                            base_q <= pte_next_base;
                            step_q <= step_q + LVL_W'(1);
                        end
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_READ);
        mem_req_addr  = pte_addr;
        mem_req_wide  = geom.wide_pte;
        done_valid    = (state_q == ST_DONE);
        done_fault    = fault_q;
        done_pa       = pa_q;
    end

    // R13
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R13
    read_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_wide ? (mem_req_addr[2:0] == 3'd0)
                                        : (mem_req_addr[1:0] == 2'd0)));

    // R14
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R14
    done_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (req_ready && !done_valid));

    // R12
    rsp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rsp_valid && mem_rsp_err)
            |=> (done_valid && done_fault));

endmodule

// File: tb/gstage_walker_bench.sv
`timescale 1ns/1ps
module gstage_walker_bench;
    localparam logic [63:0] ROOT = 64'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_gpa = '0;
    logic [3:0]  cfg_mode = '0;
    logic        cfg_narrow = 1'b0;
    logic [3:0]  cfg_cap = '0;
    logic [43:0] cfg_root_ppn = 44'(ROOT);
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_req_wide;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        done_valid, done_fault;
    logic [63:0] done_pa;

    int errors = 0;
    int checks = 0;

    logic [63:0] pmem [logic [63:0]];
    logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFF0;
    int          nreads;
    logic        last_wide;
    logic        pend = 1'b0;
    logic [63:0] paddr;

    always #2.5 clk = ~clk;

    gstage_walker u_gstage_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_gpa(req_gpa), .cfg_mode(cfg_mode), .cfg_narrow(cfg_narrow),
        .cfg_cap(cfg_cap), .cfg_root_ppn(cfg_root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_wide(mem_req_wide), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done_valid(done_valid), .done_fault(done_fault), .done_pa(done_pa)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] lookup(input logic [63:0] a);
        if (pmem.exists(a)) return pmem[a];
        return 64'd0;
    endfunction

    // Memory responder: one response, one cycle after the read is seen
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = lookup(paddr);
                mem_rsp_err   = (paddr == err_addr);
                pend = 1'b0;
            end
            if (mem_req_valid) begin
                if (pend || mem_rsp_valid)
                    chk(1'b0, "R13 overlapping read", 64'd1, 64'd0);
                pend      = 1'b1;
                paddr     = mem_req_addr;
                last_wide = mem_req_wide;
                nreads++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R14 watchdog expired actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [63:0] entry_addr(input logic [63:0] gpa, input logic [63:0] base,
                                               input int L, input int B, input int E, input int s);
        int skip, bits;
        skip = 12 + B * (L - 1 - s);
        bits = B + ((s == 0) ? 2 : 0);
        return base + ((gpa >> skip) & ((64'd1 << bits) - 64'd1)) * 64'(E);
    endfunction

    function automatic void geom_of(input logic [3:0] mode, input logic narrow, input logic [3:0] cap,
                                    output int L, output int B, output int E);
        L = 0; B = 9; E = 8;
        if (narrow) begin
            if (mode == 4'd1 && cap[0]) begin L = 2; B = 10; E = 4; end
        end else begin
            if (mode == 4'd8  && cap[1]) L = 3;
            if (mode == 4'd9  && cap[2]) L = 4;
            if (mode == 4'd10 && cap[3]) L = 5;
        end
    endfunction

    function automatic void ref_walk(input logic [63:0] gpa, input logic [3:0] mode,
                                     input logic narrow, input logic [3:0] cap,
                                     output logic f, output logic [63:0] pa, output int nr);
        int L, B, E, top, skip;
        logic [63:0] base, a, pte, ppn;
        f = 1'b0; pa = '0; nr = 0;
        if (mode == 4'd0) begin pa = gpa; return; end
        geom_of(mode, narrow, cap, L, B, E);
        if (L == 0) begin f = 1'b1; return; end
        top = 14 + B * L;
        if ((gpa >> top) != 64'd0) begin f = 1'b1; return; end
        base = ROOT << 12;
        for (int s = 0; s < L; s++) begin
            skip = 12 + B * (L - 1 - s);
            a = entry_addr(gpa, base, L, B, E, s);
            nr++;
            if (a == err_addr) begin f = 1'b1; return; end
            pte = lookup(a);
            if (E == 4) pte = pte & 64'hFFFF_FFFF;
            ppn = pte >> 10;
            if (!pte[0]) begin f = 1'b1; return; end
            if (pte[3:1] == 3'b000) begin base = ppn << 12; continue; end
            if (pte[2] && !pte[1]) begin f = 1'b1; return; end
            if ((ppn & ((64'd1 << (skip - 12)) - 64'd1)) != 64'd0) begin f = 1'b1; return; end
            pa = (ppn << 12) | (gpa & ((64'd1 << skip) - 64'd1));
            return;
        end
        f = 1'b1;
    endfunction

    task automatic build_chain(input logic [63:0] gpa, input int L, input int B, input int E,
                               input int leaf_step, input logic [3:0] flags,
                               input logic [63:0] leaf_ppn);
        logic [63:0] base, nxt;
        pmem.delete();
        base = ROOT << 12;
        for (int s = 0; s <= leaf_step; s++) begin
            if (s < leaf_step) begin
                nxt = 64'h200 + 64'(s);
                pmem[entry_addr(gpa, base, L, B, E, s)] = (nxt << 10) | 64'h1;
                base = nxt << 12;
            end else begin
                pmem[entry_addr(gpa, base, L, B, E, s)] = (leaf_ppn << 10) | 64'(flags);
            end
        end
    endtask

    task automatic run_walk(input logic [63:0] gpa, input logic [3:0] mode, input logic narrow,
                            input logic [3:0] cap, output logic f, output logic [63:0] pa);
        int cyc;
        @(negedge clk);
        nreads = 0;
        req_gpa = gpa; cfg_mode = mode; cfg_narrow = narrow; cfg_cap = cap;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done_valid && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        f = done_fault; pa = done_pa;
        chk(done_valid, "R14 done strobe missing", 64'(done_valid), 64'd1);
        @(negedge clk);
        chk(!done_valid && req_ready, "R14 done length or return to idle",
            {62'd0, done_valid, req_ready}, 64'd1);
    endtask

    task automatic compare(input string tag, input logic [63:0] gpa, input logic [3:0] mode,
                           input logic narrow, input logic [3:0] cap);
        logic ef, af;
        logic [63:0] ep, ap;
        int en, L, B, E;
        ref_walk(gpa, mode, narrow, cap, ef, ep, en);
        run_walk(gpa, mode, narrow, cap, af, ap);
        chk(af == ef, {tag, " fault"}, 64'(af), 64'(ef));
        if (!ef) chk(ap == ep, {tag, " address"}, ap, ep);
        chk(nreads == en, {tag, " read count"}, 64'(nreads), 64'(en));
        if (en > 0) begin
            geom_of(mode, narrow, cap, L, B, E);
            chk(last_wide == (E == 8), "R5 entry size", 64'(last_wide), 64'(E == 8));
        end
    endtask

    initial begin
        logic f;
        logic [63:0] pa;
        int L, B, E, top;
        logic [63:0] g, ppn_al;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_req_valid && !done_valid, "R1 during reset",
            {61'd0, req_ready, mem_req_valid, done_valid}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !done_valid, "R1 after reset",
            {61'd0, req_ready, mem_req_valid, done_valid}, 64'h4);

        // R2: bare pass-through, literal expectation
        run_walk(64'hDEAD_BEEF_0000_1234, 4'd0, 1'b0, 4'h0, f, pa);
        chk(!f && pa == 64'hDEAD_BEEF_0000_1234, "R2 bare", pa, 64'hDEAD_BEEF_0000_1234);
        chk(nreads == 0, "R2 bare read count", 64'(nreads), 64'd0);

        // R3: every mode code x capability mask x format, empty memory
        pmem.delete();
        for (int n = 0; n < 2; n++)
            for (int m = 0; m < 16; m++)
                for (int c = 0; c < 16; c++)
                    compare("R3 mode decode", 64'h0000_0000_0012_3000, 4'(m), n[0], 4'(c));

        // R5/R10: three-level 4 KiB leaf, literal expectation
        build_chain(64'h0000_0040_2030_1ABC, 3, 9, 8, 2, 4'hF, 64'h12345);
        run_walk(64'h0000_0040_2030_1ABC, 4'd8, 1'b0, 4'hF, f, pa);
        chk(!f && pa == 64'h0000_0000_1234_5ABC, "R10 three-level leaf", pa, 64'h1234_5ABC);
        chk(nreads == 3, "R5 three-level read count", 64'(nreads), 64'd3);

        // R6-R11: leaf at every step, every flag pattern, aligned/misaligned
        for (int gi = 0; gi < 4; gi++) begin
            logic [3:0] md;
            logic nw;
            md = (gi == 0) ? 4'd1 : 4'(7 + gi);
            nw = (gi == 0);
            geom_of(md, nw, 4'hF, L, B, E);
            top = 14 + B * L;
            for (int ls = 0; ls < L; ls++)
                for (int fl = 0; fl < 16; fl++)
                    for (int v = 0; v < 4; v++) begin
                        g = (v[0] ? 64'hFEDC_BA98_7654_3210 : 64'h0123_4567_89AB_CDEF)
                            & ((64'd1 << top) - 64'd1);
                        ppn_al = 64'h3 << (B * (L - 1 - ls));
                        build_chain(g, L, B, E, ls, 4'(fl), v[1] ? (ppn_al | 64'h1) : ppn_al);
                        compare("R6 R7 R8 R9 R10 R11 walk", g, md, nw, 4'hF);
                    end
            // R4: range limit bit faults, bit below is accepted
            pmem.delete();
            compare("R4 range over", 64'd1 << top, md, nw, 4'hF);
            compare("R4 range edge", 64'd1 << (top - 1), md, nw, 4'hF);
            // R11: pointers all the way down
            build_chain(64'h0, L, B, E, L - 1, 4'h1, 64'h300);
            compare("R11 pointer at last level", 64'h0, md, nw, 4'hF);
            // R12: erroring root read
            build_chain(64'h5000, L, B, E, L - 1, 4'hB, 64'h7);
            err_addr = entry_addr(64'h5000, ROOT << 12, L, B, E, 0);
            compare("R12 response error", 64'h5000, md, nw, 4'hF);
            err_addr = 64'hFFFF_FFFF_FFFF_FFF0;
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule